// File: doc/BRIEF.md
# Auto-Precharge Cross-Bank Spacing Monitor

This block watches the stream of decoded memory commands on a DDR-style command bus, one command per clock, each with its bank number. When a read or a write carrying auto-precharge is issued, the block remembers its type, its bank and the cycle it occurred in. Every later column, precharge or activate command aimed at a different bank is then measured against the minimum spacing that the pair of commands demands. If the command comes too early, a one-cycle violation pulse is raised together with the code of the offending command.

The required spacing depends on which command came first and which follows it. A read followed by a write must wait out the whole-clock CAS latency plus half the burst. A write followed by a read must cover half the burst, one extra clock and the write-to-read turnaround. Same-type pairs need half the burst. Precharge and activate need a single clock. The burst length (`BL`), the write-to-read turnaround (`TWTR`) and the CAS latency are parameters in clocks. The CAS latency is given in half clocks (`CL_HALF`, 5 meaning 2.5) and is rounded up to whole clocks at elaboration.

The control is a three-state reference machine: `S_IDLE` (no reference since reset), `S_RD_REF` (the latest auto-precharge command was a read) and `S_WR_REF` (it was a write). From any state, a read with auto-precharge moves it to `S_RD_REF` and a write with auto-precharge moves it to `S_WR_REF`. Every other command leaves the state unchanged. A saturating age counter restarts at each auto-precharge command.

Top module: `apc_gap_monitor`

## Requirements
- R1: After reset `viol` is 0 and `viol_kind` is 0, and no command is flagged until the first auto-precharge command has been seen.
- R2: After a read with auto-precharge (code 2), a read (code 1) or read with auto-precharge (code 2) to another bank with a gap below BL/2 clocks is flagged.
- R3: After a read with auto-precharge, a write (code 3) or write with auto-precharge (code 4) to another bank with a gap below ceil(CL_HALF/2) + BL/2 clocks is flagged.
- R4: After a write with auto-precharge (code 4), a read or read with auto-precharge to another bank with a gap below 1 + BL/2 + TWTR clocks is flagged.
- R5: After a write with auto-precharge, a write or write with auto-precharge to another bank with a gap below BL/2 clocks is flagged.
- R6: A precharge (code 5) or activate (code 6) to another bank needs only 1 clock after either auto-precharge type, so it is never flagged.
- R7: The gap is the number of clocks from the auto-precharge command's cycle to the later command's cycle; a gap equal to the minimum is legal.
- R8: Commands to the same bank as the tracked auto-precharge command are never flagged.
- R9: Each new auto-precharge command is first checked against the previous reference and then replaces it, including its bank.
- R10: A violation raises `viol` for exactly the one cycle after the offending command, with `viol_kind` equal to that command's code; `viol_kind` is 0 whenever `viol` is 0.
- R11: Code 0 (no operation) and code 7 (reserved) are never flagged and leave the tracked reference unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_kind | input | 3 | Command code: 0 NOP, 1 read, 2 read+AP, 3 write, 4 write+AP, 5 precharge, 6 activate, 7 reserved |
| cmd_bank | input | BANK_W | Bank addressed by the command |
| viol | output | 1 | One-cycle violation pulse |
| viol_kind | output | 3 | Code of the offending command, 0 when no violation |

## Verification
The verdict for a command presented before a rising edge is registered at that edge. It is therefore due on `viol` and `viol_kind` one clock after the command. The bench drives each command on a falling edge and compares the outputs at the next falling edge, before it drives the next command, against a model that records the cycle number of every auto-precharge command. Directed runs place later commands exactly one clock short of each minimum and exactly at it. Seeded random traffic then mixes all codes and banks.

// File: rtl/apc_pkg.sv
package apc_pkg;

    typedef enum logic [2:0] {
        C_NOP   = 3'd0,
        C_RD    = 3'd1,
        C_RD_AP = 3'd2,
        C_WR    = 3'd3,
        C_WR_AP = 3'd4,
        C_PRE   = 3'd5,
        C_ACT   = 3'd6,
        C_RSVD  = 3'd7
    } cmd_e;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_RD_REF = 2'd1,
        S_WR_REF = 2'd2
    } ref_state_e;

    function automatic logic is_read(input cmd_e k);
        return (k == C_RD) || (k == C_RD_AP);
    endfunction

    function automatic logic is_write(input cmd_e k);
        return (k == C_WR) || (k == C_WR_AP);
    endfunction

    function automatic logic is_row(input cmd_e k);
        return (k == C_PRE) || (k == C_ACT);
    endfunction

endpackage

// File: rtl/apc_ref_fsm.sv
module apc_ref_fsm
    import apc_pkg::*;
#(
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cmd_e              kind,
    input  logic [BANK_W-1:0] bank,
    output logic              ref_live,
    output logic              ref_wr,
    output logic [BANK_W-1:0] ref_bank,
    output logic              restart
);

    ref_state_e state_q, state_d;
    logic [BANK_W-1:0] bank_q;

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (kind)
            C_RD_AP: state_d = S_RD_REF;
            C_WR_AP: state_d = S_WR_REF;
            default: state_d = state_q;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            bank_q  <= '0;
        end else begin
            state_q <= state_d;
            if (kind == C_RD_AP || kind == C_WR_AP)
                bank_q <= bank;
        end
    end

    // outputs
    always_comb begin
        ref_live = 1'b0;
        ref_wr   = 1'b0;
        unique case (state_q)
            S_IDLE:   begin ref_live = 1'b0; ref_wr = 1'b0; end
            S_RD_REF: begin ref_live = 1'b1; ref_wr = 1'b0; end
            S_WR_REF: begin ref_live = 1'b1; ref_wr = 1'b1; end
            default:  begin ref_live = 1'b0; ref_wr = 1'b0; end
        endcase
        ref_bank = bank_q;
        restart  = (kind == C_RD_AP) || (kind == C_WR_AP);
    end

endmodule

// File: rtl/apc_age_counter.sv
module apc_age_counter #(
    parameter int MAX_AGE = 8,
    localparam int AGE_W  = $clog2(MAX_AGE + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    output logic [AGE_W-1:0] age
);

    localparam logic [AGE_W-1:0] AGE_TOP = AGE_W'(MAX_AGE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            age <= '0;
        else if (restart)
            age <= AGE_W'(1);
        else if (age != AGE_TOP)
            age <= age + AGE_W'(1);
    end

endmodule

// File: rtl/apc_gap_table.sv
module apc_gap_table
    import apc_pkg::*;
#(
    parameter int BL      = 4,
    parameter int CL_HALF = 5,
    parameter int TWTR    = 1,
    parameter int GAP_W   = 4
) (
    input  logic             ref_wr,
    input  cmd_e             kind,
    output logic             checked,
    output logic [GAP_W-1:0] need
);

    localparam int CL_CLK  = (CL_HALF + 1) / 2;
    localparam int HALF_BL = BL / 2;
    localparam logic [GAP_W-1:0] G_RD_RD = GAP_W'(HALF_BL);
    localparam logic [GAP_W-1:0] G_RD_WR = GAP_W'(CL_CLK + HALF_BL);
    localparam logic [GAP_W-1:0] G_WR_RD = GAP_W'(1 + HALF_BL + TWTR);
    localparam logic [GAP_W-1:0] G_WR_WR = GAP_W'(HALF_BL);
    localparam logic [GAP_W-1:0] G_ROW   = GAP_W'(1);

    always_comb begin
        checked = 1'b1;
        need    = '0;
        if (is_read(kind))
            need = ref_wr ? G_WR_RD : G_RD_RD;
        else if (is_write(kind))
            need = ref_wr ? G_WR_WR : G_RD_WR;
        else if (is_row(kind))
            need = G_ROW;
        else
            checked = 1'b0;
    end

endmodule

// File: rtl/apc_gap_monitor.sv
module apc_gap_monitor
    import apc_pkg::*;
#(
    parameter int BANK_W  = 2,
    parameter int BL      = 4,
    parameter int CL_HALF = 5,
    parameter int TWTR    = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cmd_kind,
    input  logic [BANK_W-1:0] cmd_bank,
    output logic              viol,
    output logic [2:0]        viol_kind
);

    localparam int CL_CLK  = (CL_HALF + 1) / 2;
    localparam int GAP_RW  = CL_CLK + BL / 2;
    localparam int GAP_WR  = 1 + BL / 2 + TWTR;
    localparam int MAX_GAP = (GAP_RW > GAP_WR) ? GAP_RW : GAP_WR;
    localparam int AGE_W   = $clog2(MAX_GAP + 1);

    cmd_e              kind;
    logic              ref_live;
    logic              ref_wr;
    logic [BANK_W-1:0] ref_bank;
    logic              restart;
    logic [AGE_W-1:0]  age;
    logic              checked;
    logic [AGE_W-1:0]  need;
    logic              too_soon;

    assign kind = cmd_e'(cmd_kind);

    apc_ref_fsm #(.BANK_W(BANK_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .kind     (kind),
        .bank     (cmd_bank),
        .ref_live (ref_live),
        .ref_wr   (ref_wr),
        .ref_bank (ref_bank),
        .restart  (restart)
    );

    apc_age_counter #(.MAX_AGE(MAX_GAP)) u_age (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .age     (age)
    );

    apc_gap_table #(
        .BL      (BL),
        .CL_HALF (CL_HALF),
        .TWTR    (TWTR),
        .GAP_W   (AGE_W)
    ) u_table (
        .ref_wr  (ref_wr),
        .kind    (kind),
        .checked (checked),
        .need    (need)
    );

    assign too_soon = ref_live && checked && (cmd_bank != ref_bank) && (age < need);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            viol      <= 1'b0;
            viol_kind <= 3'd0;
        end else begin
            viol      <= too_soon;
            viol_kind <= too_soon ? cmd_kind : 3'd0;
        end
    end

endmodule

// File: rtl/apc_gap_monitor_chk.sv
module apc_gap_monitor_chk #(
    parameter int BANK_W = 2,
    parameter int AGE_W  = 3,
    parameter int MAX_GAP = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        cmd_kind,
    input logic [BANK_W-1:0] cmd_bank,
    input logic              viol,
    input logic [2:0]        viol_kind,
    input logic              ref_live,
    input logic [BANK_W-1:0] ref_bank,
    input logic [AGE_W-1:0]  age
);

    // R10
    pulse_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        viol |-> viol_kind == $past(cmd_kind));

    // R10
    quiet_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !viol |-> viol_kind == 3'd0);

    // R1
    no_ref_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ref_live) |-> !viol);

    // R8
    same_bank_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ref_live) && $past(cmd_bank) == $past(ref_bank)) |-> !viol);

    // R6
    row_cmd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        viol |-> (viol_kind != 3'd5 && viol_kind != 3'd6));

    // R11
    nop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cmd_kind) == 3'd0 || $past(cmd_kind) == 3'd7) |-> !viol);

    // R11
    nop_keeps_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cmd_kind) == 3'd0) |-> (ref_bank == $past(ref_bank) && ref_live == $past(ref_live)));

    // R7
    age_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        age <= AGE_W'(MAX_GAP));

endmodule

bind apc_gap_monitor apc_gap_monitor_chk #(
    .BANK_W  (BANK_W),
    .AGE_W   (AGE_W),
    .MAX_GAP (MAX_GAP)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_kind  (cmd_kind),
    .cmd_bank  (cmd_bank),
    .viol      (viol),
    .viol_kind (viol_kind),
    .ref_live  (ref_live),
    .ref_bank  (ref_bank),
    .age       (age)
);

// File: tb/apc_gap_monitor_test.sv
module apc_gap_monitor_test;

    localparam int BANK_W  = 2;
    localparam int BL      = 4;
    localparam int CL_HALF = 5;
    localparam int TWTR    = 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [2:0]        cmd_kind = 3'd0;
    logic [BANK_W-1:0] cmd_bank = '0;
    logic              viol;
    logic [2:0]        viol_kind;

    int checks = 0;
    int failures = 0;

    bit    exp_viol = 1'b0;
    int    exp_kind = 0;
    string exp_tag = "R1";

    bit m_live = 1'b0;
    bit m_wr   = 1'b0;
    int m_bank = 0;
    int m_cyc  = 0;
    int cyc    = 0;

    always #2.5 clk = ~clk;

    apc_gap_monitor #(
        .BANK_W  (BANK_W),
        .BL      (BL),
        .CL_HALF (CL_HALF),
        .TWTR    (TWTR)
    ) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_kind  (cmd_kind),
        .cmd_bank  (cmd_bank),
        .viol      (viol),
        .viol_kind (viol_kind)
    );

    function automatic int need_gap(input bit ref_wr, input int k);
        int cl_clk = (CL_HALF + 1) / 2;
        if (k == 1 || k == 2) return ref_wr ? (1 + BL / 2 + TWTR) : (BL / 2);
        if (k == 3 || k == 4) return ref_wr ? (BL / 2) : (cl_clk + BL / 2);
        if (k == 5 || k == 6) return 1;
        return 0;
    endfunction

    function automatic string rule_tag(input bit ref_wr, input int k);
        if (k == 1 || k == 2) return ref_wr ? "R4" : "R2";
        if (k == 3 || k == 4) return ref_wr ? "R5" : "R3";
        return "R6";
    endfunction

    task automatic compare();
        checks++;
        if (viol !== exp_viol || int'(viol_kind) !== exp_kind) begin
            failures++;
            $display("FAIL %s: viol=%0b kind=%0d expected viol=%0b kind=%0d (cycle %0d)",
                     exp_tag, viol, viol_kind, exp_viol, exp_kind, cyc);
        end
    endtask

    task automatic step(input int k, input int b);
        int gap;
        int need;
        @(negedge clk);
        compare();
        cmd_kind = 3'(k);
        cmd_bank = BANK_W'(b);
        cyc++;
        exp_viol = 1'b0;
        exp_kind = 0;
        if (k == 0 || k == 7) begin
            exp_tag = "R11";
        end else if (!m_live) begin
            exp_tag = "R1";
        end else if (b == m_bank) begin
            exp_tag = "R8";
        end else begin
            gap  = cyc - m_cyc;
            need = need_gap(m_wr, k);
            exp_tag = (gap == need) ? "R7" : rule_tag(m_wr, k);
            if (k == 2 || k == 4) exp_tag = "R9";
            if (gap < need) begin
                exp_viol = 1'b1;
                exp_kind = k;
            end
        end
        if (k == 2 || k == 4) begin
            m_live = 1'b1;
            m_wr   = (k == 4);
            m_bank = b;
            m_cyc  = cyc;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0);
    endtask

    // place cmd k on bank b exactly g clocks after an AP command ap on bank 0
    task automatic pair(input int ap, input int g, input int k, input int b);
        step(ap, 0);
        idle(g - 1);
        step(k, b);
        idle(6);
    endtask

    initial begin
        int k;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        exp_tag = "R1";
        compare();
        rst_n = 1'b1;

        // R1: commands before any auto-precharge reference are never flagged
        step(1, 1); step(3, 2); step(5, 3); idle(2);

        // R2 boundary: gap 1 flagged, gap 2 legal
        pair(2, 1, 1, 1);
        pair(2, 2, 1, 1);
        // R3 boundary: gap 4 flagged, gap 5 legal
        pair(2, 4, 3, 2);
        pair(2, 5, 4, 2);
        // R4 boundary: gap 3 flagged, gap 4 legal
        pair(4, 3, 2, 3);
        pair(4, 4, 1, 3);
        // R5 boundary: gap 1 flagged, gap 2 legal
        pair(4, 1, 3, 1);
        pair(4, 2, 3, 1);
        // R6: row commands one clock after AP
        pair(2, 1, 5, 1);
        pair(4, 1, 6, 2);
        // R8: same bank right after AP
        pair(4, 1, 1, 0);
        // R11: reserved code after AP
        pair(2, 1, 7, 1);
        // R9: second AP flagged, then becomes the new reference on bank 1
        step(4, 0); step(4, 1); step(1, 1); step(1, 2); idle(6);

        for (int i = 0; i < 4000; i++) begin
            k = ($urandom % 2 == 0) ? 0 : int'($urandom % 8);
            step(k, int'($urandom % 4));
        end
        idle(2);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: run not finished, actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule